// File: doc/BRIEF.md
# Aligned-Pair Dual-Issue Controller

This controller sits between instruction decode and the execution units of a two-way in-order core. In each cycle it looks at one fetched pair of predecoded instruction descriptors and decides which of them issue. For each slot the descriptor gives an instruction class, one source register and one destination register, and the pair carries its fetch address. The controller grants issue to slot 0, to both slots, or to neither. It raises a stall flag when some instruction presented to it stays behind, and it reports the execution unit each slot takes: one of two integer ALUs, the single data-cache port, or the multiply/divide unit.

Slot 1 can go out in the same cycle as slot 0 only when the pair starts on an 8-byte boundary, slot 1 does not read slot 0's result, and the two instructions do not fight over a unit. A small per-register scoreboard keeps consumers of a load result waiting until that result is ready.

The descriptors follow a valid/ready rule. `pair_valid` marks the input as valid. `issue0` and `issue1` are the per-slot acceptances, and they depend on the current cycle's inputs. Upstream holds any slot that was not accepted. After a partial issue of an aligned pair it presents the left-over slot 1 as the new slot 0 at address +4. That address is unaligned, so the instruction issues alone.

Top module: `dual_issue_ctl`

## Requirements
- R1: Slot 1 is considered only when `pc[2]` is 0, meaning the pair is 8-byte aligned. At an unaligned `pc`, slot 0 issues alone, `issue1` stays 0, and `stall` is not raised on account of slot 1.
- R2: When slot 0's destination is nonzero and equals slot 1's source, slot 0 issues alone and `stall` is 1.
- R3: Register 0 never creates a dependency, either between the two slots or through the load scoreboard.
- R4: Integer (class 0) and branch (class 1) instructions pair freely. Slot 0 reports ALU 1 (unit code 0) and slot 1 reports ALU 2 (unit code 1).
- R5: Loads (class 2) and stores (class 3) report the cache port (unit code 2). Two memory instructions never issue in the same cycle, so slot 0 issues alone. A memory instruction paired with an ALU instruction issues together with it.
- R6: After a load issues with a nonzero destination, any slot whose source is that register is held in the next two cycles. It may issue in the third cycle after the load.
- R7: A serializing instruction (class 5, reporting unit code 0) never issues in the same cycle as another instruction.
- R8: Two multiply/divide instructions (class 4, unit code 3) never issue together. One of them paired with an ALU instruction issues together with it.
- R9: `stall` is 1 exactly when `pair_valid` is 1 and some slot presented is not issued. After reset no register is pending.
- R10: While `pair_valid` is 0, nothing issues and `stall` is 0, and the scoreboard is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pair_valid | input | 1 | Descriptors and address are valid |
| pc | input | ADDR_W | Fetch address of slot 0 |
| s0_cls | input | 3 | Slot 0 class: 0 int, 1 branch, 2 load, 3 store, 4 mul/div, 5 serializing |
| s0_src | input | REG_W | Slot 0 source register |
| s0_dst | input | REG_W | Slot 0 destination register (0 = none) |
| s1_cls | input | 3 | Slot 1 class |
| s1_src | input | REG_W | Slot 1 source register |
| s1_dst | input | REG_W | Slot 1 destination register |
| issue0 | output | 1 | Slot 0 accepted this cycle |
| issue1 | output | 1 | Slot 1 accepted this cycle |
| stall | output | 1 | A presented slot stays behind |
| unit0 | output | 2 | Unit for slot 0: 0 ALU1, 1 ALU2, 2 cache port, 3 mul/div |
| unit1 | output | 2 | Unit for slot 1 |

## Verification
Aligned pairs are tried as clean integer/branch pairs, as dependent pairs, as pairs that name register 0 on both sides, and as pairs that put two memory, two multiply/divide or serializing instructions together. Their outcomes separate the dependency check, the unit-conflict check and the register-0 exemption. The same kind of pair at an unaligned address shows that alignment alone suppresses slot 1. A load followed by the same consumer on three consecutive cycles pins down the exact length of the latency window, and an idle cycle with hazardous content shows that the valid flag gates everything.

// File: rtl/dual_issue_pkg.sv
package dual_issue_pkg;
  typedef enum logic [2:0] {
    CLS_INT    = 3'd0,
    CLS_BRANCH = 3'd1,
    CLS_LOAD   = 3'd2,
    CLS_STORE  = 3'd3,
    CLS_MULDIV = 3'd4,
    CLS_SERIAL = 3'd5
  } icls_e;

  typedef enum logic [1:0] {
    UNIT_ALU_A  = 2'd0,
    UNIT_ALU_B  = 2'd1,
    UNIT_DPORT  = 2'd2,
    UNIT_MULDIV = 2'd3
  } unit_e;

  function automatic logic cls_is_mem(input logic [2:0] c);
    return (c == CLS_LOAD) || (c == CLS_STORE);
  endfunction

  function automatic logic cls_is_muldiv(input logic [2:0] c);
    return c == CLS_MULDIV;
  endfunction

  function automatic logic cls_is_serial(input logic [2:0] c);
    return !(c <= CLS_MULDIV);
  endfunction
endpackage

// File: rtl/slot_unit_map.sv
module slot_unit_map
  import dual_issue_pkg::*;
#(
  parameter int SLOT = 0
) (
  input  logic [2:0] cls,
  output logic [1:0] unit
);
  generate
    if (SLOT == 0) begin : g_first
      always_comb begin
        if (cls_is_mem(cls))         unit = UNIT_DPORT;
        else if (cls_is_muldiv(cls)) unit = UNIT_MULDIV;
        else                         unit = UNIT_ALU_A;
      end
    end else begin : g_second
      always_comb begin
        if (cls_is_mem(cls))         unit = UNIT_DPORT;
        else if (cls_is_muldiv(cls)) unit = UNIT_MULDIV;
        else if (cls_is_serial(cls)) unit = UNIT_ALU_A;
        else                         unit = UNIT_ALU_B;
      end
    end
  endgenerate
endmodule

// File: rtl/pair_check.sv
module pair_check
  import dual_issue_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [2:0]       cls0,
  input  logic [REG_W-1:0] dst0,
  input  logic [2:0]       cls1,
  input  logic [REG_W-1:0] src1,
  output logic             depends,
  output logic             conflict
);
  always_comb begin
    depends  = (dst0 != '0) && (src1 == dst0);
    conflict = (cls_is_mem(cls0) && cls_is_mem(cls1))
             || (cls_is_muldiv(cls0) && cls_is_muldiv(cls1))
             || cls_is_serial(cls0) || cls_is_serial(cls1);
  end
endmodule

// File: rtl/load_scoreboard.sv
module load_scoreboard #(
  parameter int NREG = 32,
  parameter int LAT  = 3,
  localparam int RW  = $clog2(NREG),
  localparam int CW  = $clog2(LAT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_a,
  input  logic [RW-1:0] idx_a,
  input  logic          set_b,
  input  logic [RW-1:0] idx_b,
  input  logic [RW-1:0] q0,
  input  logic [RW-1:0] q1,
  output logic          busy0,
  output logic          busy1
);
  localparam logic [CW-1:0] RELOAD = CW'(LAT - 1);

  logic [NREG-1:0] pend;

  assign pend[0] = 1'b0;

  genvar r;
  generate
    for (r = 1; r < NREG; r++) begin : g_reg
      logic [CW-1:0] cnt;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cnt <= '0;
        end else if ((set_a && idx_a == RW'(r)) || (set_b && idx_b == RW'(r))) begin
          cnt <= RELOAD;
        end else if (cnt != '0) begin
          cnt <= cnt - 1'b1;
        end
      end
      assign pend[r] = cnt != '0;
    end
  endgenerate

  assign busy0 = pend[q0];
  assign busy1 = pend[q1];
endmodule

// File: rtl/dual_issue_ctl.sv
module dual_issue_ctl
  import dual_issue_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int NREG     = 32,
  parameter int LOAD_LAT = 3,
  localparam int REG_W   = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pair_valid,
  input  logic [ADDR_W-1:0] pc,
  input  logic [2:0]        s0_cls,
  input  logic [REG_W-1:0]  s0_src,
  input  logic [REG_W-1:0]  s0_dst,
  input  logic [2:0]        s1_cls,
  input  logic [REG_W-1:0]  s1_src,
  input  logic [REG_W-1:0]  s1_dst,
  output logic              issue0,
  output logic              issue1,
  output logic              stall,
  output logic [1:0]        unit0,
  output logic [1:0]        unit1
);
  logic aligned;
  logic depends, conflict;
  logic busy0, busy1;
  logic ld0, ld1;

  assign aligned = (pc[2] == 1'b0);

  pair_check #(.REG_W(REG_W)) u_pair (
    .cls0(s0_cls), .dst0(s0_dst), .cls1(s1_cls), .src1(s1_src),
    .depends(depends), .conflict(conflict)
  );

  slot_unit_map #(.SLOT(0)) u_map0 (.cls(s0_cls), .unit(unit0));
  slot_unit_map #(.SLOT(1)) u_map1 (.cls(s1_cls), .unit(unit1));

  assign ld0 = issue0 && (s0_cls == CLS_LOAD) && (s0_dst != '0);
  assign ld1 = issue1 && (s1_cls == CLS_LOAD) && (s1_dst != '0);

  load_scoreboard #(.NREG(NREG), .LAT(LOAD_LAT)) u_sb (
    .clk(clk), .rst_n(rst_n),
    .set_a(ld0), .idx_a(s0_dst),
    .set_b(ld1), .idx_b(s1_dst),
    .q0(s0_src), .q1(s1_src),
    .busy0(busy0), .busy1(busy1)
  );

  always_comb begin
    issue0 = pair_valid && !busy0;
    issue1 = issue0 && aligned && !depends && !conflict && !busy1;
    stall  = pair_valid && (!issue0 || (aligned && !issue1));
  end
endmodule

// File: rtl/dual_issue_chk.sv
module dual_issue_chk
  import dual_issue_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int REG_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pair_valid,
  input logic [ADDR_W-1:0] pc,
  input logic [2:0]        s0_cls,
  input logic [REG_W-1:0]  s0_src,
  input logic [REG_W-1:0]  s0_dst,
  input logic [2:0]        s1_cls,
  input logic [REG_W-1:0]  s1_src,
  input logic              issue0,
  input logic              issue1,
  input logic              stall
);
  AST_UNALIGNED_SOLO: assert property (@(posedge clk) disable iff (!rst_n)
    pc[2] |-> !issue1); // R1
  AST_DEP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (s0_dst != '0 && s1_src == s0_dst) |-> !issue1); // R2
  AST_ALU_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (issue0 && !pc[2] && s0_cls <= 3'd1 && s1_cls <= 3'd1 && (s0_dst == '0 || s1_src != s0_dst)
     && s1_src == '0) |-> issue1); // R4
  AST_ONE_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    issue1 |-> !(cls_is_mem(s0_cls) && cls_is_mem(s1_cls))); // R5
  AST_LOAD_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (issue0 && s0_cls == CLS_LOAD && s0_dst != '0)
      |=> !(issue0 && s0_src == $past(s0_dst))); // R6
  AST_SERIAL_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
    issue1 |-> !(cls_is_serial(s0_cls) || cls_is_serial(s1_cls))); // R7
  AST_ONE_MULDIV: assert property (@(posedge clk) disable iff (!rst_n)
    issue1 |-> !(cls_is_muldiv(s0_cls) && cls_is_muldiv(s1_cls))); // R8
  AST_IN_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    issue1 |-> issue0); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !pair_valid |-> !(issue0 || issue1 || stall)); // R10
endmodule

bind dual_issue_ctl dual_issue_chk #(.ADDR_W(ADDR_W), .REG_W(REG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pair_valid(pair_valid), .pc(pc),
  .s0_cls(s0_cls), .s0_src(s0_src), .s0_dst(s0_dst),
  .s1_cls(s1_cls), .s1_src(s1_src),
  .issue0(issue0), .issue1(issue1), .stall(stall)
);

// File: tb/test_dual_issue_ctl.sv
module test_dual_issue_ctl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pair_valid = 1'b0;
  logic [31:0] pc = '0;
  logic [2:0]  s0_cls = '0, s1_cls = '0;
  logic [4:0]  s0_src = '0, s0_dst = '0, s1_src = '0, s1_dst = '0;
  logic        issue0, issue1, stall;
  logic [1:0]  unit0, unit1;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [6:0] exp;
    string      tag;
  } exp_t;
  exp_t q[$];

  always #5 clk = ~clk;

  dual_issue_ctl i_dual_issue_ctl (
    .clk(clk), .rst_n(rst_n), .pair_valid(pair_valid), .pc(pc),
    .s0_cls(s0_cls), .s0_src(s0_src), .s0_dst(s0_dst),
    .s1_cls(s1_cls), .s1_src(s1_src), .s1_dst(s1_dst),
    .issue0(issue0), .issue1(issue1), .stall(stall),
    .unit0(unit0), .unit1(unit1)
  );

  task automatic drive(input logic v, input logic [31:0] a,
                       input logic [2:0] c0, input logic [4:0] r0s, input logic [4:0] r0d,
                       input logic [2:0] c1, input logic [4:0] r1s, input logic [4:0] r1d,
                       input logic ei0, input logic ei1, input logic est,
                       input logic [1:0] eu0, input logic [1:0] eu1, input string tag);
    exp_t e;
    @(posedge clk);
    #1;
    pair_valid = v; pc = a;
    s0_cls = c0; s0_src = r0s; s0_dst = r0d;
    s1_cls = c1; s1_src = r1s; s1_dst = r1d;
    e.exp = {ei0, ei1, est, eu0, eu1};
    e.tag = tag;
    q.push_back(e);
  endtask

  always @(negedge clk) begin
    if (q.size() != 0) begin
      exp_t e;
      logic [6:0] act;
      e = q.pop_front();
      act = {issue0, issue1, stall, unit0, unit1};
      checks++;
      if (act !== e.exp) begin
        errors++;
        $display("FAIL %s: got i0=%b i1=%b st=%b u0=%0d u1=%0d, expected i0=%b i1=%b st=%b u0=%0d u1=%0d",
                 e.tag, act[6], act[5], act[4], act[3:2], act[1:0],
                 e.exp[6], e.exp[5], e.exp[4], e.exp[3:2], e.exp[1:0]);
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got hang, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R9 / R10: idle after reset
    drive(0, 32'h0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, "R9 reset idle");
    // R4: int + branch aligned pair
    drive(1, 32'h100, 0, 2, 1, 1, 3, 0, 1, 1, 0, 0, 1, "R4 int+branch pair");
    // R1: unaligned, slot 1 ignored
    drive(1, 32'h104, 0, 2, 3, 0, 4, 5, 1, 0, 0, 0, 1, "R1 unaligned solo");
    // R2: dependency
    drive(1, 32'h108, 0, 2, 4, 0, 4, 6, 1, 0, 1, 0, 1, "R2 dependent pair");
    // R3: register 0 never depends
    drive(1, 32'h110, 0, 2, 0, 0, 0, 6, 1, 1, 0, 0, 1, "R3 r0 no dependency");
    // R5: load + store
    drive(1, 32'h118, 2, 1, 7, 3, 9, 0, 1, 0, 1, 2, 2, "R5 load+store");
    // R5: store + load
    drive(1, 32'h120, 3, 9, 0, 2, 1, 8, 1, 0, 1, 2, 2, "R5 store+load");
    // R8: two mul/div
    drive(1, 32'h128, 4, 10, 12, 4, 11, 13, 1, 0, 1, 3, 3, "R8 muldiv+muldiv");
    // R8: mul/div + int
    drive(1, 32'h130, 4, 10, 12, 0, 11, 14, 1, 1, 0, 3, 1, "R8 muldiv+int");
    // R7: serializing in either slot
    drive(1, 32'h138, 5, 1, 2, 0, 3, 4, 1, 0, 1, 0, 1, "R7 serial first");
    drive(1, 32'h140, 0, 1, 2, 5, 3, 4, 1, 0, 1, 0, 0, "R7 serial second");
    // R5: load + int pairs
    drive(1, 32'h148, 2, 1, 22, 0, 3, 15, 1, 1, 0, 2, 1, "R5 load+int pair");
    // R6: load latency window
    drive(1, 32'h204, 2, 1, 20, 0, 0, 0, 1, 0, 0, 2, 1, "R6 load issue");
    drive(1, 32'h208, 0, 20, 16, 0, 3, 17, 0, 0, 1, 0, 1, "R6 consumer held cycle 1");
    drive(1, 32'h208, 0, 20, 16, 0, 3, 17, 0, 0, 1, 0, 1, "R6 consumer held cycle 2");
    drive(1, 32'h208, 0, 20, 16, 0, 3, 17, 1, 1, 0, 0, 1, "R6 consumer free cycle 3");
    // R6: slot 1 hazard
    drive(1, 32'h304, 2, 1, 21, 0, 0, 0, 1, 0, 0, 2, 1, "R6 load for slot1");
    drive(1, 32'h308, 0, 1, 2, 0, 21, 3, 1, 0, 1, 0, 1, "R6 slot1 held");
    // R10: invalid cycle with hazardous content
    drive(0, 32'h310, 0, 1, 2, 0, 2, 3, 0, 0, 0, 0, 1, "R10 invalid ignored");
    // R3: load to r0 creates no pending entry
    drive(1, 32'h404, 2, 1, 0, 0, 0, 0, 1, 0, 0, 2, 1, "R3 load to r0");
    drive(1, 32'h408, 0, 0, 5, 0, 0, 6, 1, 1, 0, 0, 1, "R3 r0 source free");
    @(posedge clk);
    pair_valid = 1'b0;
    wait (q.size() == 0);
    @(posedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule